// File: doc/BRIEF.md
# Multicast Packet Router Pipeline

This block is the synchronous core of a packet-switching node. One 40-bit packet arrives per clock on a single parallel input with a valid/ready handshake. The packet passes through three registered stages. The first stage checks parity and the packet type. The second stage works out a destination set for the packet. The third stage hands a copy of the packet to every output port named in that set. There are six inter-node links, numbered 0 to 5 around a hexagon, and `NUM_LOCAL` ports that serve local processors.

Three route engines sit in the middle stage:
- Multicast packets search a masked associative table; the first matching entry wins. A packet that matches nothing leaves on the link opposite the one it arrived on.
- Point-to-point packets index a direct table.
- Nearest-neighbour packets name their link in the packet itself.

If a link output stays not-ready for a programmed number of cycles, its copy is redirected to the two links on either side of it, and the event is reported with a pulse. If copies are still stuck after a second such window, they are discarded. All tables and the blocking limit are written through a small register-style write port.

Top module: `mcast_router`

## Requirements
- R1: After reset every output valid is low, `in_ready` is high, the error count is zero and both event pulses are low.
- R2: Parity is even over all 40 bits, with bit 39 as the parity bit. A packet with odd parity, or with type code 3 in bits 38:37, produces no output copy, and the error count increases by one (saturating).
- R3: For a multicast packet (type 0), routing key = bits 31:0. An entry matches when (key AND entry mask) equals the entry key. The route vector of the lowest-numbered matching entry is used.
- R4: A multicast packet that matches no entry goes to link (s+3) mod 6, where s is the source field in bits 36:34. If s is 6 or 7, the packet is discarded.
- R5: A point-to-point packet (type 1) uses the route vector stored at table index key[log2(P2P_ENTRIES)-1:0].
- R6: A nearest-neighbour packet (type 2) goes to link key[2:0] when that value is 0 to 5, and to all six links when it is 6 or 7.
- R7: With all outputs ready, a packet accepted at clock edge k appears on its outputs after edge k+2. Back-to-back packets flow at one per clock.
- R8: While any selected output has not taken its copy, `out_data` holds steady and the pipeline stalls: `in_ready` drops once the stages behind are full. No packet is lost or reordered.
- R9: When a link copy stays undelivered for L consecutive cycles (L = programmed limit), it moves to links (k+1) mod 6 and (k+5) mod 6, and `emg_pulse` is high for one cycle.
- R10: Copies that are still undelivered L cycles after the emergency step are discarded, and `drop_pulse` is high for one cycle. A blocked local port has no emergency step; it is dropped after 2L cycles.
- R11: Configuration writes use `cfg_addr` = {select[2:0], index}. The select codes are:
  - 0: multicast key
  - 1: multicast mask
  - 2: multicast route vector
  - 3: point-to-point route vector
  - 4: blocking limit

  Route vectors use bit i for output i: links are bits 0 to 5 and local ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input packet valid |
| in_data | input | 40 | Input packet |
| in_ready | output | 1 | Router can accept a packet |
| out_data | output | 40 | Packet shared by all outputs |
| out_valid | output | NUM_OUT | Per-output copy valid |
| out_ready | input | NUM_OUT | Per-output copy taken |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | IDX_W+3 | Select and table index |
| cfg_wdata | input | 32 | Configuration write data |
| err_count | output | ERR_W | Dropped-packet error count |
| emg_pulse | output | 1 | Emergency reroute occurred |
| drop_pulse | output | 1 | Undelivered copies discarded |

## Verification
The bench builds the router with two local ports, so there are eight outputs in total. It uses four multicast entries and four point-to-point entries, so index fields are two bits wide and overlapping table entries can be placed in a few writes. Reprogramming the blocking limit down to 4 brings both the emergency step and the final discard within about ten cycles. A limit of 200 holds a stall long enough to fill every stage and observe `in_ready` low.

// File: rtl/mrt_pkg.sv
package mrt_pkg;
  localparam int PKT_W     = 40;
  localparam int KEY_W     = 32;
  localparam int NUM_LINKS = 6;

  typedef enum logic [1:0] {
    PT_MCAST = 2'd0,
    PT_P2P   = 2'd1,
    PT_NEIGH = 2'd2,
    PT_RSVD  = 2'd3
  } ptype_e;

  localparam logic [2:0] SEL_KEY   = 3'd0;
  localparam logic [2:0] SEL_MASK  = 3'd1;
  localparam logic [2:0] SEL_MCVEC = 3'd2;
  localparam logic [2:0] SEL_P2P   = 3'd3;
  localparam logic [2:0] SEL_LIMIT = 3'd4;

  function automatic logic [5:0] link_bit(input logic [2:0] n);
    return (n < 3'd6) ? (6'd1 << n) : 6'd0;
  endfunction

  // neighbours around the hexagon: k+1 and k+5 (mod 6)
  function automatic logic [5:0] hex_nb(input logic [5:0] v);
    return {v[4:0], v[5]} | {v[0], v[5:1]};
  endfunction
endpackage

// File: rtl/rtr_classify.sv
module rtr_classify
  import mrt_pkg::*;
#(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [PKT_W-1:0] in_data,
  output logic             in_ready,
  input  logic             dn_ready,
  output logic             s1_valid,
  output logic [PKT_W-1:0] s1_pkt,
  output logic [ERR_W-1:0] err_count
);
  logic s1_v, s1_bad;

  assign in_ready = !s1_v || dn_ready;
  assign s1_valid = s1_v && !s1_bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v      <= 1'b0;
      s1_bad    <= 1'b0;
      err_count <= '0;
    end else begin
      if (in_ready) begin
        s1_v   <= in_valid;
        s1_pkt <= in_data;
        s1_bad <= (^in_data) || (in_data[38:37] == PT_RSVD);
      end
      if (s1_v && s1_bad && dn_ready && (err_count != '1))
        err_count <= err_count + 1'b1;
    end
  end

  AST_ERR_MONO: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (err_count >= $past(err_count))); // R2
endmodule

// File: rtl/rtr_route.sv
module rtr_route
  import mrt_pkg::*;
#(
  parameter int NUM_OUT     = 8,
  parameter int MC_ENTRIES  = 4,
  parameter int P2P_ENTRIES = 4,
  parameter int IDX_W       = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_sel,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [KEY_W-1:0]   cfg_wdata,
  input  logic               s1_valid,
  input  logic [PKT_W-1:0]   s1_pkt,
  output logic               up_ready,
  input  logic               dn_ready,
  output logic               s2_valid,
  output logic [PKT_W-1:0]   s2_pkt,
  output logic [NUM_OUT-1:0] s2_vec
);
  localparam int NUM_LOCAL = NUM_OUT - NUM_LINKS;
  localparam int MC_IW     = $clog2(MC_ENTRIES);
  localparam int P2P_IW    = $clog2(P2P_ENTRIES);

  logic [KEY_W-1:0]   mc_key  [MC_ENTRIES];
  logic [KEY_W-1:0]   mc_mask [MC_ENTRIES];
  logic [NUM_OUT-1:0] mc_vec  [MC_ENTRIES];
  logic [NUM_OUT-1:0] p2p_vec [P2P_ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < MC_ENTRIES; e++) begin
        mc_key[e]  <= '1;
        mc_mask[e] <= '0;
        mc_vec[e]  <= '0;
      end
      for (int e = 0; e < P2P_ENTRIES; e++) p2p_vec[e] <= '0;
    end else if (cfg_we) begin
      if (int'(cfg_idx) < MC_ENTRIES) begin
        if (cfg_sel == SEL_KEY)   mc_key[cfg_idx[MC_IW-1:0]]  <= cfg_wdata;
        if (cfg_sel == SEL_MASK)  mc_mask[cfg_idx[MC_IW-1:0]] <= cfg_wdata;
        if (cfg_sel == SEL_MCVEC) mc_vec[cfg_idx[MC_IW-1:0]]  <= cfg_wdata[NUM_OUT-1:0];
      end
      if (int'(cfg_idx) < P2P_ENTRIES && cfg_sel == SEL_P2P)
        p2p_vec[cfg_idx[P2P_IW-1:0]] <= cfg_wdata[NUM_OUT-1:0];
    end
  end

  logic [KEY_W-1:0] key;
  logic [2:0]       src;
  ptype_e           ptyp;
  assign key  = s1_pkt[KEY_W-1:0];
  assign src  = s1_pkt[36:34];
  assign ptyp = ptype_e'(s1_pkt[38:37]);

  logic [MC_ENTRIES-1:0] match;
  for (genvar e = 0; e < MC_ENTRIES; e++) begin : g_cam
    assign match[e] = ((key & mc_mask[e]) == mc_key[e]);
  end

  logic [NUM_OUT-1:0] hit_vec, route_vec;
  logic [5:0]         dflt, neigh;
  logic [2:0]         opp;

  always_comb begin
    hit_vec = '0;
    for (int e = MC_ENTRIES - 1; e >= 0; e--)
      if (match[e]) hit_vec = mc_vec[e];
    opp   = (src >= 3'd3) ? src - 3'd3 : src + 3'd3;
    dflt  = (src < 3'd6) ? link_bit(opp) : 6'd0;
    neigh = (key[2:0] < 3'd6) ? link_bit(key[2:0]) : 6'h3F;
    case (ptyp)
      PT_MCAST: route_vec = (|match) ? hit_vec : {{NUM_LOCAL{1'b0}}, dflt};
      PT_P2P:   route_vec = p2p_vec[key[P2P_IW-1:0]];
      PT_NEIGH: route_vec = {{NUM_LOCAL{1'b0}}, neigh};
      default:  route_vec = '0;
    endcase
  end

  assign up_ready = !s2_valid || dn_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid <= 1'b0;
    end else if (up_ready) begin
      s2_valid <= s1_valid && (route_vec != '0);
      s2_pkt   <= s1_pkt;
      s2_vec   <= route_vec;
    end
  end
endmodule

// File: rtl/rtr_replicate.sv
module rtr_replicate
  import mrt_pkg::*;
#(
  parameter int NUM_OUT   = 8,
  parameter int LIMIT_W   = 8,
  parameter int DEF_LIMIT = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lim_we,
  input  logic [LIMIT_W-1:0] lim_data,
  input  logic               in_valid,
  input  logic [PKT_W-1:0]   in_pkt,
  input  logic [NUM_OUT-1:0] in_vec,
  output logic               up_ready,
  output logic [PKT_W-1:0]   out_data,
  output logic [NUM_OUT-1:0] out_valid,
  input  logic [NUM_OUT-1:0] out_ready,
  output logic               emg_pulse,
  output logic               drop_pulse
);
  localparam int NUM_LOCAL = NUM_OUT - NUM_LINKS;

  logic [NUM_OUT-1:0] pend, left, pend_n, nb_ext, blk_ext;
  logic [LIMIT_W-1:0] cnt, limit;
  logic [LIMIT_W:0]   cnt_plus;
  logic               used, fire, emg_n, drop_n;
  logic [5:0]         blk;

  assign out_valid = pend;

  always_comb begin
    left     = pend & ~out_ready;
    cnt_plus = {1'b0, cnt} + {{LIMIT_W{1'b0}}, 1'b1};
    fire     = (left != '0) && (cnt_plus >= {1'b0, limit});
    blk      = used ? 6'd0 : left[5:0];
    blk_ext  = {{NUM_LOCAL{1'b0}}, blk};
    nb_ext   = {{NUM_LOCAL{1'b0}}, hex_nb(blk)};
    pend_n   = left;
    emg_n    = 1'b0;
    drop_n   = 1'b0;
    if (fire) begin
      if (!used) begin
        pend_n = (left & ~blk_ext) | nb_ext;
        emg_n  = (blk != 6'd0);
      end else begin
        pend_n = '0;
        drop_n = 1'b1;
      end
    end
  end

  assign up_ready = (pend_n == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend       <= '0;
      cnt        <= '0;
      used       <= 1'b0;
      limit      <= LIMIT_W'(DEF_LIMIT);
      emg_pulse  <= 1'b0;
      drop_pulse <= 1'b0;
    end else begin
      if (lim_we) limit <= lim_data;
      emg_pulse  <= emg_n;
      drop_pulse <= drop_n;
      if (up_ready) begin
        pend <= in_valid ? in_vec : '0;
        if (in_valid) out_data <= in_pkt;
        cnt  <= '0;
        used <= 1'b0;
      end else begin
        pend <= pend_n;
        if (fire) begin
          cnt  <= '0;
          used <= 1'b1;
        end else if (left != '0) begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (|(out_valid & ~out_ready)) |=> ($stable(out_data) || drop_pulse)); // R8
  AST_EMG_SUBST: assert property (@(posedge clk) disable iff (rst)
    emg_pulse |-> ((out_valid & $past(nb_ext)) == $past(nb_ext))); // R9
  AST_DROP_AFTER_WAIT: assert property (@(posedge clk) disable iff (rst)
    drop_pulse |-> ($past(out_valid) != '0)); // R10
endmodule

// File: rtl/mcast_router.sv
module mcast_router
  import mrt_pkg::*;
#(
  parameter int NUM_LOCAL   = 2,
  parameter int MC_ENTRIES  = 4,
  parameter int P2P_ENTRIES = 4,
  parameter int ERR_W       = 8,
  parameter int LIMIT_W     = 8,
  parameter int DEF_LIMIT   = 16,
  localparam int NUM_OUT    = NUM_LINKS + NUM_LOCAL,
  localparam int IDX_W      = $clog2((MC_ENTRIES > P2P_ENTRIES) ? MC_ENTRIES : P2P_ENTRIES),
  localparam int ADDR_W     = IDX_W + 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [PKT_W-1:0]   in_data,
  output logic               in_ready,
  output logic [PKT_W-1:0]   out_data,
  output logic [NUM_OUT-1:0] out_valid,
  input  logic [NUM_OUT-1:0] out_ready,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [KEY_W-1:0]   cfg_wdata,
  output logic [ERR_W-1:0]   err_count,
  output logic               emg_pulse,
  output logic               drop_pulse
);
  logic [2:0]         cfg_sel;
  logic [IDX_W-1:0]   cfg_idx;
  logic               s1_valid, s2_valid, s2_up_ready, s3_up_ready;
  logic [PKT_W-1:0]   s1_pkt, s2_pkt;
  logic [NUM_OUT-1:0] s2_vec;

  assign cfg_sel = cfg_addr[ADDR_W-1:IDX_W];
  assign cfg_idx = cfg_addr[IDX_W-1:0];

  rtr_classify #(.ERR_W(ERR_W)) u_classify (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .dn_ready(s2_up_ready), .s1_valid(s1_valid),
    .s1_pkt(s1_pkt), .err_count(err_count)
  );

  rtr_route #(.NUM_OUT(NUM_OUT), .MC_ENTRIES(MC_ENTRIES),
              .P2P_ENTRIES(P2P_ENTRIES), .IDX_W(IDX_W)) u_route (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .s1_valid(s1_valid),
    .s1_pkt(s1_pkt), .up_ready(s2_up_ready), .dn_ready(s3_up_ready),
    .s2_valid(s2_valid), .s2_pkt(s2_pkt), .s2_vec(s2_vec)
  );

  rtr_replicate #(.NUM_OUT(NUM_OUT), .LIMIT_W(LIMIT_W),
                  .DEF_LIMIT(DEF_LIMIT)) u_replicate (
    .clk(clk), .rst(rst), .lim_we(cfg_we && (cfg_sel == SEL_LIMIT)),
    .lim_data(cfg_wdata[LIMIT_W-1:0]), .in_valid(s2_valid),
    .in_pkt(s2_pkt), .in_vec(s2_vec), .up_ready(s3_up_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .emg_pulse(emg_pulse), .drop_pulse(drop_pulse)
  );

  AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (out_valid == '0) |-> in_ready); // R8
endmodule

// File: tb/mcast_router_tb_top.sv
`timescale 1ns/1ps
module mcast_router_tb_top;
  localparam int NOUT = 8;

  logic             clk = 1'b0;
  logic             rst;
  logic             in_valid;
  logic [39:0]      in_data;
  logic             in_ready;
  logic [39:0]      out_data;
  logic [NOUT-1:0]  out_valid;
  logic [NOUT-1:0]  out_ready;
  logic             cfg_we;
  logic [4:0]       cfg_addr;
  logic [31:0]      cfg_wdata;
  logic [7:0]       err_count;
  logic             emg_pulse, drop_pulse;

  int vectors = 0;
  int miscompares = 0;

  always #2.5 clk = ~clk;

  mcast_router #(.NUM_LOCAL(2), .MC_ENTRIES(4), .P2P_ENTRIES(4),
                 .ERR_W(8), .LIMIT_W(8), .DEF_LIMIT(16)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .err_count(err_count), .emg_pulse(emg_pulse),
    .drop_pulse(drop_pulse)
  );

  function automatic logic [39:0] mk(input logic [1:0] t, input logic [2:0] s,
                                     input logic [31:0] k);
    logic [38:0] body;
    body = {t, s, 2'b00, k};
    return {^body, body};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [2:0] sel, input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {sel, idx}; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drive one packet, check its copies after the third edge, then idle
  task automatic send_expect(input logic [39:0] p, input logic [NOUT-1:0] exp, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_data = p;
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(req, 64'(out_valid), 64'(exp));
    if (exp != '0) chk(req, 64'(out_data), 64'(p));
    @(negedge clk);
    chk(req, 64'(out_valid), 64'd0);
  endtask

  task automatic t_reset();
    chk("R1 out_valid", 64'(out_valid), 64'd0);
    chk("R1 in_ready", 64'(in_ready), 64'd1);
    chk("R1 err_count", 64'(err_count), 64'd0);
    chk("R1 pulses", 64'({emg_pulse, drop_pulse}), 64'd0);
  endtask

  task automatic t_mcast();   // R3 and R11
    cfg_wr(3'd0, 2'd0, 32'h1234_0000); cfg_wr(3'd1, 2'd0, 32'hFFFF_0000); cfg_wr(3'd2, 2'd0, 32'h41);
    cfg_wr(3'd0, 2'd1, 32'h1234_5600); cfg_wr(3'd1, 2'd1, 32'hFFFF_FF00); cfg_wr(3'd2, 2'd1, 32'h82);
    cfg_wr(3'd0, 2'd2, 32'hAB00_0000); cfg_wr(3'd1, 2'd2, 32'hFF00_0000); cfg_wr(3'd2, 2'd2, 32'h06);
    send_expect(mk(2'd0, 3'd0, 32'h1234_5678), 8'h41, "R3 lowest entry wins");
    send_expect(mk(2'd0, 3'd2, 32'h1234_0001), 8'h41, "R3 entry0 hit");
    send_expect(mk(2'd0, 3'd2, 32'hAB12_3456), 8'h06, "R11 entry2 programmed");
  endtask

  task automatic t_default();
    send_expect(mk(2'd0, 3'd1, 32'h5555_0000), 8'h10, "R4 src1 to link4");
    send_expect(mk(2'd0, 3'd4, 32'h5555_0000), 8'h02, "R4 src4 to link1");
    send_expect(mk(2'd0, 3'd7, 32'h5555_0000), 8'h00, "R4 local src dropped");
  endtask

  task automatic t_p2p();
    cfg_wr(3'd3, 2'd2, 32'h80);
    cfg_wr(3'd3, 2'd1, 32'h44);
    send_expect(mk(2'd1, 3'd0, 32'h0000_0002), 8'h80, "R5 index2");
    send_expect(mk(2'd1, 3'd0, 32'hFFFF_FFF5), 8'h44, "R5 index1");
  endtask

  task automatic t_neigh();
    send_expect(mk(2'd2, 3'd0, 32'h5), 8'h20, "R6 link5");
    send_expect(mk(2'd2, 3'd0, 32'h8), 8'h01, "R6 link0");
    send_expect(mk(2'd2, 3'd0, 32'h7), 8'h3F, "R6 all links");
  endtask

  task automatic t_parity();
    send_expect(mk(2'd2, 3'd0, 32'h1) ^ {1'b1, 39'd0}, 8'h00, "R2 parity drop");
    chk("R2 err count 1", 64'(err_count), 64'd1);
    send_expect(mk(2'd3, 3'd0, 32'h1), 8'h00, "R2 type3 drop");
    chk("R2 err count 2", 64'(err_count), 64'd2);
  endtask

  task automatic t_stream();  // R7: one per clock, three-edge latency
    logic [39:0] p [4];
    for (int i = 0; i < 4; i++) p[i] = mk(2'd2, 3'd0, 32'(i + 1));
    for (int j = 0; j < 7; j++) begin
      @(negedge clk);
      if (j == 2) chk("R7 no early output", 64'(out_valid), 64'd0);
      if (j >= 3) begin
        chk("R7 stream valid", 64'(out_valid), 64'(8'h01 << (j - 2)));
        chk("R7 stream data", 64'(out_data), 64'(p[j-3]));
      end
      in_valid = (j < 4);
      if (j < 4) in_data = p[j];
    end
    in_valid = 1'b0;
  endtask

  task automatic t_stall();   // R8
    logic [39:0] a, b, c, d;
    cfg_wr(3'd4, 2'd0, 32'd200);
    cfg_wr(3'd3, 2'd3, 32'h40);
    a = mk(2'd1, 3'd0, 32'h3); b = mk(2'd2, 3'd0, 32'h0);
    c = mk(2'd2, 3'd0, 32'h1); d = mk(2'd2, 3'd0, 32'h2);
    @(negedge clk); out_ready = 8'hBF; in_valid = 1'b1; in_data = a;
    @(negedge clk); in_data = b;
    @(negedge clk); in_data = c;
    @(negedge clk); in_data = d;
    chk("R8 in_ready low when full", 64'(in_ready), 64'd0);
    chk("R8 blocked copy", 64'(out_valid), 64'h40);
    repeat (3) @(negedge clk);
    chk("R8 data held", 64'(out_data), 64'(a));
    chk("R8 still stalled", 64'(in_ready), 64'd0);
    out_ready = 8'hFF;
    @(negedge clk); in_valid = 1'b0;
    chk("R8 next b", 64'({out_valid, out_data}), 64'({8'h01, b}));
    @(negedge clk);
    chk("R8 next c", 64'({out_valid, out_data}), 64'({8'h02, c}));
    @(negedge clk);
    chk("R8 next d", 64'({out_valid, out_data}), 64'({8'h04, d}));
    @(negedge clk);
    chk("R8 drained", 64'(out_valid), 64'd0);
  endtask

  task automatic t_emergency();  // R9, limit 4
    cfg_wr(3'd4, 2'd0, 32'd4);
    @(negedge clk); out_ready = 8'hFB; in_valid = 1'b1; in_data = mk(2'd2, 3'd0, 32'h2);
    @(negedge clk); in_valid = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R9 link2 pending", 64'(out_valid), 64'h04);
    repeat (3) @(negedge clk);
    chk("R9 not yet rerouted", 64'({emg_pulse, out_valid}), 64'h004);
    @(negedge clk);
    chk("R9 neighbours 1 and 3", 64'(out_valid), 64'h0A);
    chk("R9 emg pulse", 64'(emg_pulse), 64'd1);
    @(negedge clk);
    chk("R9 delivered, pulse ends", 64'({emg_pulse, out_valid}), 64'h000);
    out_ready = 8'hFF;
  endtask

  task automatic t_timeout();  // R10, local port 7 blocked, limit 4
    cfg_wr(3'd3, 2'd0, 32'h80);
    @(negedge clk); out_ready = 8'h7F; in_valid = 1'b1; in_data = mk(2'd1, 3'd0, 32'h0);
    @(negedge clk); in_valid = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R10 local pending", 64'(out_valid), 64'h80);
    repeat (4) @(negedge clk);
    chk("R10 no emergency for local", 64'({emg_pulse, out_valid}), 64'h080);
    repeat (3) @(negedge clk);
    chk("R10 still pending", 64'({drop_pulse, out_valid}), 64'h080);
    @(negedge clk);
    chk("R10 dropped", 64'({drop_pulse, out_valid}), 64'h100);
    out_ready = 8'hFF;
  endtask

  initial begin
    #(200000 * 5);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_data = '0; out_ready = 8'hFF;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mcast();
    t_default();
    t_p2p();
    t_neigh();
    t_parity();
    t_stream();
    t_stall();
    t_emergency();
    t_timeout();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule